// File: doc/BRIEF.md
# Thirty-Two-Line GPIO with Twin Interrupt Banks

This block is a memory-mapped general-purpose I/O controller for up to thirty-two lines. Each line is either driven by the block from its output data register or sensed as an input. Sensed inputs pass through a two-flop synchronizer. Each input line can then raise an interrupt on a high level, a low level, a rising transition or a falling transition, and each of these four detect types has its own enable register. One qualifying event sets the same bit in two independent status/enable banks. Each bank drives its own interrupt output, so two processors can each take their own subset of the lines.

A wakeup output pulses when an event arrives on a line whose wakeup enable is set, but only while the configuration register enables wakeup and selects a nonzero idle mode. Atomic set and clear alias addresses are provided for the output data, for both interrupt enables and for the wakeup enable. The register port takes byte, halfword and word accesses. Narrow writes to ordinary registers are merged into the current contents. Narrow writes to status and alias addresses treat the unwritten bytes as zero.

Top module: `gpio_dual_irq`

## Requirements
- R1: After reset the configuration register (0x10) reads 0, control (0x30) reads 2, output-enable (0x34) reads all ones, status 0x18/0x28, enables 0x1C/0x2C, wakeup-enable 0x20, level-low 0x40, level-high 0x44, rise 0x48, fall 0x4C and debounce-enable 0x50 read 0. The reset-done register 0x14 always reads 1 and address 0x00 reads the REV_ID parameter.
- R2: `pin_out` equals the output data register (0x3C). `pin_drive` is the inverse of output-enable, where a 1 in output-enable marks the line as an input. The input data register (0x38) shows `pin_in` after two synchronizer flops.
- R3: On a line whose output-enable bit is 1, a 0-to-1 change with its rise bit (0x48) set, or a high level with its level-high bit (0x44) set, sets that line's status bit. Lines with output-enable 0 never set status.
- R4: On an input line, a 1-to-0 change with its fall bit (0x4C) set, or a low level with its level-low bit (0x40) set, sets that line's status bit.
- R5: One event sets the same bit in both status banks. `irq_a` is the OR of (status 0x18 AND enable 0x1C), and `irq_b` is the OR of (status 0x28 AND enable 0x2C).
- R6: Writing ones to a status register clears those bits, and only those bits. A line whose level condition still holds sets its bit again on the following cycle.
- R7: The alias addresses set or clear bits of their register: enable-A clear/set 0x60/0x64, enable-B 0x70/0x74, wakeup-enable 0x80/0x84, output data 0x90/0x94. Reading an alias returns the underlying register.
- R8: The size encoding is 0 byte, 1 halfword, 2 word. Write data sits in the low bits and is shifted to the lane at address bits [1:0] (halfword at bit 1). Ordinary registers keep their unwritten bytes. Status and alias writes see unwritten bytes as zero. Reads return the addressed word shifted right by 8 times address bits [1:0].
- R9: The configuration register keeps only the bits of mask 0x1D, and control keeps only its low 3 bits. A configuration write with bit 1 set returns every register except output data to its reset value, and the configuration register then takes the written value masked.
- R10: `wake` pulses for one cycle, the cycle after an event on a line whose wakeup-enable bit is set, only if configuration bit 2 is 1 and configuration bits 4:3 are nonzero.
- R11: Writes to the revision, reset-done and input data addresses change nothing.
- R12: Debounce-enable (0x50, one bit per line) and debounce-time (0x54, 8 bits) are stored and read back and have no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data, low-aligned |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | NLINES | Asynchronous line inputs |
| pin_out | output | NLINES | Output data to the pads |
| pin_drive | output | NLINES | 1 where the pad is driven |
| irq_a | output | 1 | Interrupt of bank A |
| irq_b | output | 1 | Interrupt of bank B |
| wake | output | 1 | One-cycle wakeup pulse |

## Verification
The bench builds the block with NLINES set to 16 and REV_ID set to 0xA5. With sixteen lines, every line can be swept one by one through rising and falling detection in both banks. Halfword and byte lanes above bit 15 also become observable as truncated. The wakeup gating is tried with each of its three qualifying conditions removed in turn. Level re-assertion after a clear, soft reset, lane merging of narrow writes and the zero-fill of alias writes are each exercised with values computed in the bench.

// File: rtl/gpio_dual_pkg.sv
package gpio_dual_pkg;

  localparam logic [7:0] A_REV     = 8'h00;
  localparam logic [7:0] A_SYSCFG  = 8'h10;
  localparam logic [7:0] A_SYSSTAT = 8'h14;
  localparam logic [7:0] A_ST1     = 8'h18;
  localparam logic [7:0] A_EN1     = 8'h1C;
  localparam logic [7:0] A_WKEN    = 8'h20;
  localparam logic [7:0] A_ST2     = 8'h28;
  localparam logic [7:0] A_EN2     = 8'h2C;
  localparam logic [7:0] A_CTRL    = 8'h30;
  localparam logic [7:0] A_OE      = 8'h34;
  localparam logic [7:0] A_DIN     = 8'h38;
  localparam logic [7:0] A_DOUT    = 8'h3C;
  localparam logic [7:0] A_LVL0    = 8'h40;
  localparam logic [7:0] A_LVL1    = 8'h44;
  localparam logic [7:0] A_RISE    = 8'h48;
  localparam logic [7:0] A_FALL    = 8'h4C;
  localparam logic [7:0] A_DBEN    = 8'h50;
  localparam logic [7:0] A_DBT     = 8'h54;
  localparam logic [7:0] A_EN1_CLR = 8'h60;
  localparam logic [7:0] A_EN1_SET = 8'h64;
  localparam logic [7:0] A_EN2_CLR = 8'h70;
  localparam logic [7:0] A_EN2_SET = 8'h74;
  localparam logic [7:0] A_WK_CLR  = 8'h80;
  localparam logic [7:0] A_WK_SET  = 8'h84;
  localparam logic [7:0] A_DO_CLR  = 8'h90;
  localparam logic [7:0] A_DO_SET  = 8'h94;

  localparam logic [4:0] CFG_KEEP  = 5'h1D;
  localparam logic [2:0] CTRL_INIT = 3'd2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  // bit offset of the addressed lane
  function automatic logic [4:0] lane_shift(input logic [1:0] lo, input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return {lo, 3'b000};
      SZ_HALF: return {lo[1], 4'b0000};
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [31:0] lane_mask(input logic [1:0] lo, input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 32'h0000_00FF << lane_shift(lo, sz);
      SZ_HALF: return 32'h0000_FFFF << lane_shift(lo, sz);
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // keep=1 merges into cur, keep=0 fills unwritten lanes with zero
  function automatic logic [31:0] merge_write(input logic [31:0] cur, input logic [31:0] wd,
                                              input logic [1:0] lo, input logic [1:0] sz,
                                              input logic keep);
    logic [31:0] m;
    logic [31:0] v;
    m = lane_mask(lo, sz);
    v = (wd << lane_shift(lo, sz)) & m;
    return keep ? ((cur & ~m) | v) : v;
  endfunction

  function automatic logic [31:0] hit_up(input logic [31:0] now, input logic [31:0] prev,
                                         input logic [31:0] edge_en, input logic [31:0] lvl_en);
    return (now & ~prev & edge_en) | (now & lvl_en);
  endfunction

  function automatic logic [31:0] hit_down(input logic [31:0] now, input logic [31:0] prev,
                                           input logic [31:0] edge_en, input logic [31:0] lvl_en);
    return (~now & prev & edge_en) | (~now & lvl_en);
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] now_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;
  logic [W-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign now_o  = sync_q;
  assign prev_o = hist_q;
endmodule

// File: rtl/gpio_event_det.sv
module gpio_event_det
  import gpio_dual_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] now_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] sense_i,
  input  logic [W-1:0] lvl_lo_i,
  input  logic [W-1:0] lvl_hi_i,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  output logic [W-1:0] ev_o
);
  logic [W-1:0] up_w;
  logic [W-1:0] down_w;

  assign up_w   = W'(hit_up(32'(now_i), 32'(prev_i), 32'(rise_i), 32'(lvl_hi_i)));
  assign down_w = W'(hit_down(32'(now_i), 32'(prev_i), 32'(fall_i), 32'(lvl_lo_i)));
  assign ev_o   = sense_i & (up_w | down_w);
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst_i,
  input  logic [W-1:0] ev_i,
  input  logic [W-1:0] clr_i,
  input  logic         en_load_i,
  input  logic         en_set_i,
  input  logic         en_clr_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] alias_val_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] enable_o,
  output logic         irq_o
);
  logic [W-1:0] st_q;
  logic [W-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      en_q <= '0;
    end else if (soft_rst_i) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      st_q <= (st_q & ~clr_i) | ev_i;
      if (en_load_i)     en_q <= load_val_i;
      else if (en_set_i) en_q <= en_q | alias_val_i;
      else if (en_clr_i) en_q <= en_q & ~alias_val_i;
    end
  end

  assign status_o = st_q;
  assign enable_o = en_q;
  assign irq_o    = |(st_q & en_q);

  // R5: an event is latched into status on the next edge
  p_event_latched_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ev_i) && !soft_rst_i) |=> ((status_o & $past(ev_i)) == $past(ev_i)));

  // R6: cleared bits without a fresh event read zero
  p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(clr_i & ~ev_i)) && !soft_rst_i) |=> ((status_o & $past(clr_i & ~ev_i)) == '0));
endmodule

// File: rtl/gpio_dual_irq.sv
module gpio_dual_irq
  import gpio_dual_pkg::*;
#(
  parameter int         NLINES = 32,
  parameter logic [7:0] REV_ID = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [7:0]        bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] pin_out,
  output logic [NLINES-1:0] pin_drive,
  output logic              irq_a,
  output logic              irq_b,
  output logic              wake
);
  localparam int W      = NLINES;
  localparam int NBANKS = 2;

  // register state
  logic [4:0]   cfg_q;
  logic [2:0]   ctrl_q;
  logic [W-1:0] oe_q, dout_q, wken_q;
  logic [W-1:0] lvl0_q, lvl1_q, rise_q, fall_q, dben_q;
  logic [7:0]   dbt_q;
  logic         wake_q;

  // bus decode
  logic [7:0]  wa;
  logic [1:0]  lo;
  logic        wr;
  logic [31:0] rd_word;
  logic [31:0] merged, raw;
  logic [W-1:0] merged_w, raw_w;
  logic        soft_rst;

  // detection
  logic [W-1:0] pin_now, pin_prev, ev;
  logic [W-1:0] bank_st [NBANKS];
  logic [W-1:0] bank_en [NBANKS];
  logic [NBANKS-1:0] bank_irq;

  assign wa = {bus_addr[7:2], 2'b00};
  assign lo = bus_addr[1:0];
  assign wr = bus_sel && bus_we;

  function automatic logic hit(input logic [7:0] a, input logic [7:0] target, input logic w);
    return w && (a == target);
  endfunction

  always_comb begin
    case (wa)
      A_REV:                           rd_word = 32'(REV_ID);
      A_SYSCFG:                        rd_word = 32'(cfg_q);
      A_SYSSTAT:                       rd_word = 32'd1;
      A_ST1:                           rd_word = 32'(bank_st[0]);
      A_EN1, A_EN1_CLR, A_EN1_SET:     rd_word = 32'(bank_en[0]);
      A_WKEN, A_WK_CLR, A_WK_SET:      rd_word = 32'(wken_q);
      A_ST2:                           rd_word = 32'(bank_st[1]);
      A_EN2, A_EN2_CLR, A_EN2_SET:     rd_word = 32'(bank_en[1]);
      A_CTRL:                          rd_word = 32'(ctrl_q);
      A_OE:                            rd_word = 32'(oe_q);
      A_DIN:                           rd_word = 32'(pin_now);
      A_DOUT, A_DO_CLR, A_DO_SET:      rd_word = 32'(dout_q);
      A_LVL0:                          rd_word = 32'(lvl0_q);
      A_LVL1:                          rd_word = 32'(lvl1_q);
      A_RISE:                          rd_word = 32'(rise_q);
      A_FALL:                          rd_word = 32'(fall_q);
      A_DBEN:                          rd_word = 32'(dben_q);
      A_DBT:                           rd_word = 32'(dbt_q);
      default:                         rd_word = 32'd0;
    endcase
  end

  assign bus_rdata = bus_sel ? (rd_word >> {lo, 3'b000}) : 32'd0;

  assign merged   = merge_write(rd_word, bus_wdata, lo, bus_size, 1'b1);
  assign raw      = merge_write(32'd0, bus_wdata, lo, bus_size, 1'b0);
  assign merged_w = W'(merged);
  assign raw_w    = W'(raw);
  assign soft_rst = hit(wa, A_SYSCFG, wr) && merged[1];

  // configuration and line registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      ctrl_q <= CTRL_INIT;
      oe_q   <= '1;
      dout_q <= '0;
      wken_q <= '0;
      lvl0_q <= '0;
      lvl1_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
      dben_q <= '0;
      dbt_q  <= '0;
    end else begin
      if (hit(wa, A_SYSCFG, wr)) cfg_q <= merged[4:0] & CFG_KEEP;

      if (hit(wa, A_DOUT, wr))        dout_q <= merged_w;
      else if (hit(wa, A_DO_SET, wr)) dout_q <= dout_q | raw_w;
      else if (hit(wa, A_DO_CLR, wr)) dout_q <= dout_q & ~raw_w;

      if (soft_rst) begin
        ctrl_q <= CTRL_INIT;
        oe_q   <= '1;
        wken_q <= '0;
        lvl0_q <= '0;
        lvl1_q <= '0;
        rise_q <= '0;
        fall_q <= '0;
        dben_q <= '0;
        dbt_q  <= '0;
      end else begin
        if (hit(wa, A_CTRL, wr)) ctrl_q <= merged[2:0];
        if (hit(wa, A_OE, wr))   oe_q   <= merged_w;
        if (hit(wa, A_LVL0, wr)) lvl0_q <= merged_w;
        if (hit(wa, A_LVL1, wr)) lvl1_q <= merged_w;
        if (hit(wa, A_RISE, wr)) rise_q <= merged_w;
        if (hit(wa, A_FALL, wr)) fall_q <= merged_w;
        if (hit(wa, A_DBEN, wr)) dben_q <= merged_w;
        if (hit(wa, A_DBT, wr))  dbt_q  <= merged[7:0];
        if (hit(wa, A_WKEN, wr))        wken_q <= merged_w;
        else if (hit(wa, A_WK_SET, wr)) wken_q <= wken_q | raw_w;
        else if (hit(wa, A_WK_CLR, wr)) wken_q <= wken_q & ~raw_w;
      end
    end
  end

  gpio_in_sync #(.W(W)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_in),
    .now_o  (pin_now),
    .prev_o (pin_prev)
  );

  gpio_event_det #(.W(W)) u_det (
    .now_i    (pin_now),
    .prev_i   (pin_prev),
    .sense_i  (oe_q),
    .lvl_lo_i (lvl0_q),
    .lvl_hi_i (lvl1_q),
    .rise_i   (rise_q),
    .fall_i   (fall_q),
    .ev_o     (ev)
  );

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    localparam logic [7:0] ST_A  = (b == 0) ? A_ST1     : A_ST2;
    localparam logic [7:0] EN_A  = (b == 0) ? A_EN1     : A_EN2;
    localparam logic [7:0] SET_A = (b == 0) ? A_EN1_SET : A_EN2_SET;
    localparam logic [7:0] CLR_A = (b == 0) ? A_EN1_CLR : A_EN2_CLR;

    gpio_irq_bank #(.W(W)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .soft_rst_i  (soft_rst),
      .ev_i        (ev),
      .clr_i       (hit(wa, ST_A, wr) ? raw_w : '0),
      .en_load_i   (hit(wa, EN_A, wr)),
      .en_set_i    (hit(wa, SET_A, wr)),
      .en_clr_i    (hit(wa, CLR_A, wr)),
      .load_val_i  (merged_w),
      .alias_val_i (raw_w),
      .status_o    (bank_st[b]),
      .enable_o    (bank_en[b]),
      .irq_o       (bank_irq[b])
    );
  end

  // wakeup pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= !soft_rst && cfg_q[2] && (cfg_q[4:3] != 2'b00) && (|(ev & wken_q));
  end

  assign wake      = wake_q;
  assign irq_a     = bank_irq[0];
  assign irq_b     = bank_irq[1];
  assign pin_out   = dout_q;
  assign pin_drive = ~oe_q;

  // R5: both banks see the same event
  p_both_banks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ev) && !soft_rst) |=> ((bank_st[0] & bank_st[1] & $past(ev)) == $past(ev)));

  // R9: soft reset restores direction and control
  p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> ((oe_q == '1) && (ctrl_q == CTRL_INIT) && (bank_en[0] == '0)));

  // R10: a wake pulse needs wakeup enabled and a nonzero idle mode
  p_wake_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(cfg_q[2] && (cfg_q[4:3] != 2'b00)));
endmodule

// File: tb/tb_gpio_dual_irq.sv
module tb_gpio_dual_irq;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [1:0]  bus_size = 2'd2;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pin_in = '0, pin_out, pin_drive;
  logic        irq_a, irq_b, wake;

  int errs = 0, checks = 0;
  logic saw_wake = 1'b0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  gpio_dual_irq #(.NLINES(N), .REV_ID(8'hA5)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_drive(pin_drive), .irq_a(irq_a), .irq_b(irq_b), .wake(wake)
  );

  always @(negedge clk) if (wake) saw_wake <= 1'b1;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = 2'd2;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic pins(input logic [N-1:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic clr_all();
    wr(8'h18, 32'hFFFF);
    wr(8'h28, 32'hFFFF);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rdchk("R1 cfg", 8'h10, 0);
    rdchk("R1 ctrl", 8'h30, 2);
    rdchk("R1 oe", 8'h34, 32'hFFFF);
    rdchk("R1 st1", 8'h18, 0);
    rdchk("R1 en2", 8'h2C, 0);
    rdchk("R1 rise", 8'h48, 0);
    rdchk("R1 sysstat", 8'h14, 1);
    rdchk("R1 rev", 8'h00, 32'hA5);
    chk("R1 irq", {30'd0, irq_a, irq_b}, 0);

    // R2 pads and input path
    wr(8'h34, 32'h0);
    wr(8'h3C, 32'h1234);
    chk("R2 drive", 32'(pin_drive), 32'hFFFF);
    chk("R2 out", 32'(pin_out), 32'h1234);
    pins(16'hBEEF);
    rdchk("R2 din", 8'h38, 32'hBEEF);
    wr(8'h34, 32'hFFFF);
    chk("R2 drive off", 32'(pin_drive), 0);

    // R3 rising sweep, R5 both banks
    wr(8'h48, 32'hFFFF);
    pins('0);
    clr_all();
    for (int i = 0; i < N; i++) begin
      pins(N'(1) << i);
      rdchk($sformatf("R3 rise line %0d", i), 8'h18, 32'(1) << i);
      rdchk($sformatf("R5 bank2 line %0d", i), 8'h28, 32'(1) << i);
      pins('0);
      clr_all();
    end
    wr(8'h34, 32'hFFF7);
    pins(16'h0008);
    rdchk("R3 output line ignored", 8'h18, 0);
    pins('0);
    wr(8'h34, 32'hFFFF);
    wr(8'h48, 32'h0);

    // R4 falling sweep
    wr(8'h4C, 32'hFFFF);
    pins(16'hFFFF);
    clr_all();
    for (int i = 0; i < N; i++) begin
      pins(~(N'(1) << i));
      rdchk($sformatf("R4 fall line %0d", i), 8'h18, 32'(1) << i);
      pins(16'hFFFF);
      clr_all();
    end

    // R5 interrupt outputs, R7 enable aliases
    pins(16'hFFDF);
    wr(8'h4C, 32'h0);
    chk("R5 no enable", {30'd0, irq_a, irq_b}, 0);
    wr(8'h1C, 32'h0020);
    chk("R5 irq_a only", {30'd0, irq_a, irq_b}, 2);
    wr(8'h74, 32'h0020);
    chk("R5 both irq", {30'd0, irq_a, irq_b}, 3);
    wr(8'h60, 32'h0020);
    chk("R7 en1 clear", {30'd0, irq_a, irq_b}, 1);
    rdchk("R7 en1 read", 8'h64, 0);
    rdchk("R7 en2 read", 8'h70, 32'h20);
    wr(8'h70, 32'hFFFF);
    pins('0);
    clr_all();

    // R6 level reassertion and w1c
    wr(8'h44, 32'h0001);
    pins(16'h0001);
    rdchk("R6 level high set", 8'h18, 1);
    wr(8'h18, 32'h1);
    rdchk("R6 reasserted", 8'h18, 1);
    wr(8'h44, 32'h0);
    wr(8'h18, 32'h1);
    rdchk("R6 cleared", 8'h18, 0);
    pins('0);
    wr(8'h40, 32'h0002);
    rdchk("R4 level low", 8'h18, 2);
    wr(8'h40, 32'h0);
    clr_all();

    // R7 output and wakeup aliases
    wr(8'h3C, 32'h00F0);
    wr(8'h94, 32'h000F);
    chk("R7 dout set", 32'(pin_out), 32'h00FF);
    rdchk("R7 alias read", 8'h94, 32'h00FF);
    wr(8'h90, 32'h00F0);
    chk("R7 dout clr", 32'(pin_out), 32'h000F);
    wr(8'h84, 32'h0101);
    wr(8'h80, 32'h0001);
    rdchk("R7 wken", 8'h20, 32'h0100);
    wr(8'h20, 32'h0);

    // R8 narrow accesses
    wr(8'h3C, 32'h1234);
    wr(8'h3D, 32'hAB, 2'd0);
    rdchk("R8 byte merge", 8'h3C, 32'hAB34);
    wr(8'h3E, 32'h5555, 2'd1);
    rdchk("R8 half above width", 8'h3C, 32'hAB34);
    rdchk("R8 byte read", 8'h3D, 32'h00AB);
    wr(8'h48, 32'h0101);
    pins(16'h0101);
    rdchk("R8 status setup", 8'h18, 32'h0101);
    wr(8'h19, 32'h01, 2'd0);
    rdchk("R8 status byte clear", 8'h18, 32'h0001);
    wr(8'h1C, 32'h0);
    wr(8'h65, 32'h80, 2'd0);
    rdchk("R8 alias byte", 8'h1C, 32'h8000);
    pins('0);
    wr(8'h48, 32'h0);
    clr_all();

    // R9 sysconfig mask and soft reset
    wr(8'h30, 32'h5);
    wr(8'h34, 32'h0);
    wr(8'h10, 32'hFF);
    rdchk("R9 cfg mask", 8'h10, 32'h1D);
    rdchk("R9 oe reset", 8'h34, 32'hFFFF);
    rdchk("R9 ctrl reset", 8'h30, 2);
    rdchk("R9 en1 reset", 8'h1C, 0);
    rdchk("R9 dout kept", 8'h3C, 32'hAB34);
    wr(8'h30, 32'hFF);
    rdchk("R9 ctrl mask", 8'h30, 7);

    // R10 wakeup gating
    wr(8'h48, 32'h0010);
    wr(8'h84, 32'h0010);
    for (int k = 0; k < 4; k++) begin
      logic [31:0] cfg;
      logic [31:0] wk;
      cfg = (k == 1) ? 32'h04 : (k == 2) ? 32'h18 : 32'h1C;
      wk  = (k == 3) ? 32'h0 : 32'h10;
      wr(8'h10, cfg);
      wr(8'h20, wk);
      pins('0);
      saw_wake = 1'b0;
      pins(16'h0010);
      chk($sformatf("R10 wake case %0d", k), 32'(saw_wake), (k == 0) ? 1 : 0);
    end
    pins('0);

    // R11 read-only addresses
    wr(8'h38, 32'hFFFF);
    wr(8'h00, 32'hFF);
    wr(8'h14, 32'hFF);
    rdchk("R11 din", 8'h38, 0);
    rdchk("R11 rev", 8'h00, 32'hA5);
    rdchk("R11 sysstat", 8'h14, 1);

    // R12 debounce storage
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'h54, 32'h1FF);
    rdchk("R12 dben", 8'h50, 32'hFFFF);
    rdchk("R12 dbt", 8'h54, 32'hFF);
    chk("R12 no irq", {30'd0, irq_a, irq_b}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule